// File: doc/BRIEF.md
# Translation Lookaside Buffer with Global Entries

This block caches recent virtual-to-physical page translations for a 32-bit address space. Small (4 KB) pages and large (4 MB) pages live in two separate fully associative arrays, each of eight entries. Every request searches both arrays at the same time. Small entries are tagged with the 20-bit virtual page number. Large entries are tagged with the 10-bit large-page number. Because the sizes never share storage, a small mapping and a large mapping that cover the same address do not conflict.

A page walker writes a new translation through the fill port after a miss. Software-driven events reach the block as two strobes. A single-page invalidate drops the matching entry from both arrays. A page-directory base reload drops every entry, except that entries marked global survive while the global-enable input is high. The page attributes are opaque to the block: it stores them and returns them. It performs no permission or caching decision.

Top module: `xlat_tlb`

## Requirements
- R1: After synchronous active-low reset both arrays are empty, so every lookup returns lk_hit=0.
- R2: Lookup is combinational. A small-page fill with fill_present=1 is written at the next rising edge. From then on, any address with the same bits 31:12 hits in the same cycle it is presented, and returns the filled 20-bit frame and 6-bit attribute.
- R3: A large-page fill (fill_large=1) stores fill_frame[19:10] as the large frame base and is tagged by address bits 31:22. A hit returns lk_frame = {base, lk_vaddr[21:12]} with lk_large=1.
- R4: When both arrays hit the same address, the large-page result is returned.
- R5: A fill whose tag already exists in its array overwrites that entry in place, so a later lookup returns the new frame and attribute and never a stale one.
- R6: An allocating fill takes the lowest-numbered invalid entry. With no entry free, it replaces the entry at a round-robin pointer that starts at 0 after reset and advances by one only on such a replacement.
- R7: A fill with fill_present=0 writes nothing.
- R8: A base reload with global_en=1 removes all entries whose global flag is clear and keeps global ones.
- R9: A single-page invalidate removes the matching entry from both arrays (small tag bits 31:12, large tag bits 31:22), whether or not it is global.
- R10: A base reload with global_en=0 removes every entry, global ones included.
- R11: A fill in the same cycle as a reload or invalidate is applied after them, so the filled entry is present afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_large | output | 1 | Hit came from the large-page array |
| lk_frame | output | 20 | Physical 4 KB frame number of the hit |
| lk_attr | output | 6 | Stored attributes of the hit |
| fill_valid | input | 1 | Fill strobe |
| fill_vaddr | input | 32 | Virtual address being filled |
| fill_large | input | 1 | 1 selects the large-page array |
| fill_frame | input | 20 | Frame number (upper 10 bits used for large pages) |
| fill_attr | input | 6 | Attributes to store |
| fill_global | input | 1 | Global flag of the translation |
| fill_present | input | 1 | Present flag; 0 suppresses the fill |
| inv_valid | input | 1 | Single-page invalidate strobe |
| inv_vaddr | input | 32 | Address to invalidate |
| base_reload | input | 1 | Page-directory base reload event |
| global_en | input | 1 | 1 lets global entries survive a reload |

## Verification
A fill can land in the same cycle as a base reload that flushes the array it writes. The bench provokes this after filling the small array to capacity. It raises fill_valid together with base_reload while global_en is 1. It then judges by lookups that the new non-global page hits, while a non-global page filled earlier misses. A targeted invalidate that falls on an occupied slot of a full array also competes with the round-robin pointer. The next fill must go to the freed slot rather than the pointed one, and the bench shows this by which old page still hits.

// File: rtl/xlat_tlb_pkg.sv
// Package: shared sizes for the translation lookaside buffer.
// Assumes 32-bit virtual addresses with 4 KB and 4 MB page granules.
package xlat_tlb_pkg;
    parameter int VA_W       = 32;
    parameter int SMALL_SH   = 12;
    parameter int LARGE_SH   = 22;
    parameter int ATTR_W     = 6;
    parameter int N_ENTRIES  = 8;
    localparam int FRAME_W   = VA_W - SMALL_SH;
    localparam int LBASE_W   = VA_W - LARGE_SH;
endpackage

// File: rtl/xlat_rr_victim.sv
// Module: victim selector for one entry array.
// Picks the lowest invalid entry, else a round-robin pointer that moves
// only when a valid entry is actually replaced. Assumes alloc_en is
// raised only for fills that allocate (no tag match).
module xlat_rr_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               alloc_en,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Find the lowest-numbered free entry.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim_idx = any_free ? free_idx : ptr_q;
    end

    // Advance the round-robin pointer on each replacement of a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (alloc_en && !any_free) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    AST_PTR_HOLD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && any_free) |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/xlat_tlb_array.sv
// Module: one fully associative entry array of the TLB.
// Holds tag, data, attributes and a global flag per entry. Lookup is
// combinational; invalidate and flush clear entries, then a write (if any)
// is applied on the same edge. Assumes at most one entry per tag, which
// the in-place overwrite keeps true.
module xlat_tlb_array #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 20,
    parameter int ATTR_W  = 6,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              wr_global,
    input  logic              inv_en,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic              flush_en,
    input  logic              keep_global
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] global_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [ATTR_W-1:0]  attr_q [ENTRIES];

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic [ENTRIES-1:0] inv_match;
    logic [ENTRIES-1:0] clear_mask;
    logic [IDX_W-1:0]   match_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               wr_hit;

    // Per-entry tag comparators for lookup, fill and invalidate.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]  = valid_q[g] && (tag_q[g] == lk_tag);
        assign wr_match[g]  = valid_q[g] && (tag_q[g] == wr_tag);
        assign inv_match[g] = valid_q[g] && (tag_q[g] == inv_tag);
    end

    // Merge the (at most one) matching entry onto the lookup outputs.
    always_comb begin
        lk_hit  = |lk_match;
        lk_data = '0;
        lk_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_data = lk_data | data_q[i];
                lk_attr = lk_attr | attr_q[i];
            end
        end
    end

    // Encode the entry that already holds the fill tag.
    always_comb begin
        wr_hit    = |wr_match;
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_match[i]) match_idx = IDX_W'(i);
        end
    end

    xlat_rr_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_q),
        .alloc_en   (wr_en && !wr_hit),
        .victim_idx (victim_idx)
    );

    assign wr_idx = wr_hit ? match_idx : victim_idx;

    // Entries removed this cycle by invalidate or base reload.
    always_comb begin
        clear_mask = inv_en ? inv_match : '0;
        if (flush_en) clear_mask = clear_mask | (keep_global ? ~global_q : '1);
    end

    // Update valid bits: clear first, then set the written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) valid_q[i] <= 1'b1;
                else if (clear_mask[i])             valid_q[i] <= 1'b0;
            end
        end
    end

    // Write the payload of the selected entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tag_q[i]    <= wr_tag;
                data_q[i]   <= wr_data;
                attr_q[i]   <= wr_attr;
                global_q[i] <= wr_global;
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R5
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]); // R2
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inv_en && !flush_en) |=> $stable(valid_q)); // R7
    AST_RELOAD_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && keep_global && !wr_en && !inv_en) |=>
        (valid_q == ($past(valid_q) & $past(global_q)))); // R8
    AST_RELOAD_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !keep_global && !wr_en) |=> (valid_q == '0)); // R10
endmodule

// File: rtl/xlat_tlb.sv
// Module: TLB top with a small-page and a large-page array.
// Both arrays are searched in parallel; a large-page hit wins. Fills with
// the present flag clear are dropped. A base reload flushes non-global
// entries (all entries when global_en is 0); invalidate hits both arrays.
module xlat_tlb
    import xlat_tlb_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES,
    parameter int AW      = ATTR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               lk_hit,
    output logic               lk_large,
    output logic [FRAME_W-1:0] lk_frame,
    output logic [AW-1:0]      lk_attr,
    input  logic               fill_valid,
    input  logic [VA_W-1:0]    fill_vaddr,
    input  logic               fill_large,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic [AW-1:0]      fill_attr,
    input  logic               fill_global,
    input  logic               fill_present,
    input  logic               inv_valid,
    input  logic [VA_W-1:0]    inv_vaddr,
    input  logic               base_reload,
    input  logic               global_en
);
    localparam int SUB_W = LARGE_SH - SMALL_SH;

    logic               sm_hit, lg_hit;
    logic [FRAME_W-1:0] sm_frame;
    logic [LBASE_W-1:0] lg_base;
    logic [AW-1:0]      sm_attr, lg_attr;
    logic               fill_ok;

    assign fill_ok = fill_valid && fill_present;

    xlat_tlb_array #(
        .ENTRIES(ENTRIES), .TAG_W(FRAME_W), .DATA_W(FRAME_W), .ATTR_W(AW)
    ) i_small (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_tag      (lk_vaddr[VA_W-1:SMALL_SH]),
        .lk_hit      (sm_hit),
        .lk_data     (sm_frame),
        .lk_attr     (sm_attr),
        .wr_en       (fill_ok && !fill_large),
        .wr_tag      (fill_vaddr[VA_W-1:SMALL_SH]),
        .wr_data     (fill_frame),
        .wr_attr     (fill_attr),
        .wr_global   (fill_global),
        .inv_en      (inv_valid),
        .inv_tag     (inv_vaddr[VA_W-1:SMALL_SH]),
        .flush_en    (base_reload),
        .keep_global (global_en)
    );

    xlat_tlb_array #(
        .ENTRIES(ENTRIES), .TAG_W(LBASE_W), .DATA_W(LBASE_W), .ATTR_W(AW)
    ) i_large (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_tag      (lk_vaddr[VA_W-1:LARGE_SH]),
        .lk_hit      (lg_hit),
        .lk_data     (lg_base),
        .lk_attr     (lg_attr),
        .wr_en       (fill_ok && fill_large),
        .wr_tag      (fill_vaddr[VA_W-1:LARGE_SH]),
        .wr_data     (fill_frame[FRAME_W-1:SUB_W]),
        .wr_attr     (fill_attr),
        .wr_global   (fill_global),
        .inv_en      (inv_valid),
        .inv_tag     (inv_vaddr[VA_W-1:LARGE_SH]),
        .flush_en    (base_reload),
        .keep_global (global_en)
    );

    // Select the result: large-page hit has priority over small-page hit.
    always_comb begin
        lk_hit   = sm_hit || lg_hit;
        lk_large = lg_hit;
        if (lg_hit) begin
            lk_frame = {lg_base, lk_vaddr[LARGE_SH-1:SMALL_SH]};
            lk_attr  = lg_attr;
        end else begin
            lk_frame = sm_hit ? sm_frame : '0;
            lk_attr  = sm_hit ? sm_attr  : '0;
        end
    end

    AST_LARGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_hit && lg_hit) |-> (lk_large && lk_attr == lg_attr)); // R4
    AST_LARGE_FRAME_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lk_large |-> (lk_frame[SUB_W-1:0] == lk_vaddr[LARGE_SH-1:SMALL_SH])); // R3
    AST_NO_NONPRESENT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_present && !lk_hit && !inv_valid && !base_reload
         && lk_vaddr == fill_vaddr && $stable(lk_vaddr)) |=> !lk_hit); // R7
endmodule

// File: tb/test_xlat_tlb.sv
// Bench for xlat_tlb: a vector table walked by one loop, then directed
// tests for replacement, same-cycle fill/reload and reset.
module test_xlat_tlb;
    localparam logic [2:0] OP_LOOK = 3'd0;
    localparam logic [2:0] OP_FILL = 3'd1;
    localparam logic [2:0] OP_INV  = 3'd2;
    localparam logic [2:0] OP_RLD  = 3'd3;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] va;
        logic        lg;
        logic [19:0] fr;
        logic [5:0]  at;
        logic        gl;
        logic        pr;
        logic        pge;
        logic        eh;
        logic [19:0] ef;
        logic [5:0]  ea;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{OP_LOOK, 32'h0040_1000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd1},
        '{OP_FILL, 32'h0040_1000, 1'b0, 20'h12345, 6'h05, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd2},
        '{OP_LOOK, 32'h0040_1ABC, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'h12345, 6'h05, 8'd2},
        '{OP_FILL, 32'h00C0_0000, 1'b1, 20'hAB000, 6'h0A, 1'b1, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd3},
        '{OP_LOOK, 32'h00C4_5123, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'hAB045, 6'h0A, 8'd3},
        '{OP_FILL, 32'h00C4_5000, 1'b0, 20'h11111, 6'h01, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd4},
        '{OP_LOOK, 32'h00C4_5000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'hAB045, 6'h0A, 8'd4},
        '{OP_LOOK, 32'h00C4_6000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'hAB046, 6'h0A, 8'd3},
        '{OP_FILL, 32'h0040_2000, 1'b0, 20'h22222, 6'h02, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0,     6'h00, 8'd7},
        '{OP_LOOK, 32'h0040_2000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd7},
        '{OP_FILL, 32'h0040_1000, 1'b0, 20'h54321, 6'h03, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd5},
        '{OP_LOOK, 32'h0040_1000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'h54321, 6'h03, 8'd5},
        '{OP_RLD,  32'h0,         1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd8},
        '{OP_LOOK, 32'h0040_1000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd8},
        '{OP_LOOK, 32'h00C4_7000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'hAB047, 6'h0A, 8'd8},
        '{OP_LOOK, 32'h00C4_5000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b1, 20'hAB045, 6'h0A, 8'd8},
        '{OP_INV,  32'h00C4_7FFF, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd9},
        '{OP_LOOK, 32'h00C4_7000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd9},
        '{OP_FILL, 32'h0100_0000, 1'b1, 20'h40000, 6'h11, 1'b1, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd10},
        '{OP_RLD,  32'h0,         1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0,     6'h00, 8'd10},
        '{OP_LOOK, 32'h0100_0000, 1'b0, 20'h0,     6'h00, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0,     6'h00, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_vaddr;
    logic        lk_hit, lk_large;
    logic [19:0] lk_frame;
    logic [5:0]  lk_attr;
    logic        fill_valid, fill_large, fill_global, fill_present;
    logic [31:0] fill_vaddr;
    logic [19:0] fill_frame;
    logic [5:0]  fill_attr;
    logic        inv_valid, base_reload, global_en;
    logic [31:0] inv_vaddr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    xlat_tlb i_xlat_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_large(lk_large),
        .lk_frame(lk_frame), .lk_attr(lk_attr),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_large(fill_large),
        .fill_frame(fill_frame), .fill_attr(fill_attr), .fill_global(fill_global),
        .fill_present(fill_present),
        .inv_valid(inv_valid), .inv_vaddr(inv_vaddr),
        .base_reload(base_reload), .global_en(global_en)
    );

    task automatic idle();
        fill_valid = 0; fill_vaddr = 0; fill_large = 0; fill_frame = 0;
        fill_attr = 0; fill_global = 0; fill_present = 1;
        inv_valid = 0; inv_vaddr = 0; base_reload = 0; global_en = 1;
    endtask

    // Check a lookup result in the current cycle (inputs set at negedge).
    task automatic check_look(input logic [31:0] va, input logic eh,
                              input logic [19:0] ef, input logic [5:0] ea,
                              input string req);
        lk_vaddr = va;
        #1;
        checks++;
        if (lk_hit !== eh || (eh && (lk_frame !== ef || lk_attr !== ea))) begin
            failures++;
            $display("FAIL %s va=%h hit=%b frame=%h attr=%h expected hit=%b frame=%h attr=%h",
                     req, va, lk_hit, lk_frame, lk_attr, eh, ef, ea);
        end
    endtask

    task automatic fill4k(input logic [31:0] va, input logic [19:0] fr);
        @(negedge clk);
        idle();
        fill_valid = 1; fill_vaddr = va; fill_frame = fr; fill_attr = 6'h01;
        @(negedge clk);
        idle();
    endtask

    task automatic expect4k(input logic [31:0] va, input logic eh,
                            input logic [19:0] fr, input string req);
        check_look(va, eh, fr, 6'h01, req);
    endtask

    initial begin
        #(5 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        lk_vaddr = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // Vector table: one operation per cycle.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            idle();
            global_en = VEC[k].pge;
            case (VEC[k].op)
                OP_FILL: begin
                    fill_valid = 1; fill_vaddr = VEC[k].va; fill_large = VEC[k].lg;
                    fill_frame = VEC[k].fr; fill_attr = VEC[k].at;
                    fill_global = VEC[k].gl; fill_present = VEC[k].pr;
                end
                OP_INV:  begin inv_valid = 1; inv_vaddr = VEC[k].va; end
                OP_RLD:  base_reload = 1;
                default: check_look(VEC[k].va, VEC[k].eh, VEC[k].ef, VEC[k].ea,
                                    $sformatf("R%0d vec%0d", VEC[k].req, k));
            endcase
        end
        @(negedge clk);
        idle();

        // R6: arrays are empty now; fill eight small pages into slots 0..7.
        for (int p = 0; p < 8; p++) fill4k(32'h0001_0000 + (p << 12), 20'h30000 + 20'(p));
        expect4k(32'h0001_7000, 1'b1, 20'h30007, "R6 eighth fill");
        fill4k(32'h0001_8000, 20'h30008);           // replaces slot 0
        expect4k(32'h0001_0000, 1'b0, 20'h0, "R6 slot0 evicted");
        expect4k(32'h0001_1000, 1'b1, 20'h30001, "R6 slot1 kept");
        expect4k(32'h0001_8000, 1'b1, 20'h30008, "R6 new page");
        // Free slot 3; next fill must use it and leave the pointer at 1.
        @(negedge clk);
        inv_valid = 1; inv_vaddr = 32'h0001_3000;
        @(negedge clk);
        idle();
        expect4k(32'h0001_3000, 1'b0, 20'h0, "R9 small invalidate");
        fill4k(32'h0001_9000, 20'h30009);
        expect4k(32'h0001_1000, 1'b1, 20'h30001, "R6 invalid slot first");
        expect4k(32'h0001_9000, 1'b1, 20'h30009, "R6 fill into freed slot");
        fill4k(32'h0001_A000, 20'h3000A);           // replaces slot 1
        expect4k(32'h0001_1000, 1'b0, 20'h0, "R6 pointer advanced to 1");
        expect4k(32'h0001_2000, 1'b1, 20'h30002, "R6 slot2 kept");

        // R11: fill in the same cycle as a global-preserving reload.
        @(negedge clk);
        idle();
        base_reload = 1; global_en = 1;
        fill_valid = 1; fill_vaddr = 32'h0002_0000; fill_frame = 20'h3BEEF; fill_attr = 6'h01;
        @(negedge clk);
        idle();
        expect4k(32'h0002_0000, 1'b1, 20'h3BEEF, "R11 fill survives reload");
        expect4k(32'h0001_2000, 1'b0, 20'h0, "R11 old non-global flushed");

        // R9: invalidate removes a global large page despite global flag.
        @(negedge clk);
        fill_valid = 1; fill_large = 1; fill_global = 1;
        fill_vaddr = 32'h0200_0000; fill_frame = 20'h81C00; fill_attr = 6'h2A;
        @(negedge clk);
        idle();
        check_look(32'h0230_1000, 1'b1, 20'h81F01, 6'h2A, "R3 large frame concat");
        @(negedge clk);
        inv_valid = 1; inv_vaddr = 32'h023F_F000;
        @(negedge clk);
        idle();
        check_look(32'h0200_0000, 1'b0, 20'h0, 6'h0, "R9 global large invalidated");

        // R1: reset in mid-run empties both arrays.
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        expect4k(32'h0002_0000, 1'b0, 20'h0, "R1 reset clears");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule